// File: doc/BRIEF.md
# Write-Through Invalidate Cache Coherence Controller

This block controls one small direct-mapped, write-through cache that shares a snooping bus with other caches. Each line carries one valid bit, a tag and one data word. A line is either Valid or Invalid, and an address that is not resident counts as Invalid. A read that finds its line Valid is answered locally with no bus traffic. A read miss and every write first win the bus, then drive one bus command.

The controller watches writes made by the other caches on the bus. A foreign write that names a block held Valid here turns that line Invalid. Writes become visible in the order their commands win the bus, and invalidations take effect in that same order. Any number of caches may hold the same block Valid for reading.

Address split: the low `IDX_W` bits of an address select the line, and the remaining upper bits form the tag. On the bus, `bus_cmd_wr` = 1 marks a write and 0 marks a read.

The sequencer has three states, and each one is named below:
- `ST_IDLE`: a read hit completes here. It stays in `ST_IDLE` when there is no request, on a hit, and when a snoop collides with the access. A read miss or any write moves it to `ST_WAIT`.
- `ST_WAIT`: the bus request is held. It stays here until grant, then moves to `ST_ISSUE`.
- `ST_ISSUE`: drives the command for one cycle, raises done, and returns to `ST_IDLE`.

Top module: `wtinv_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `bus_cmd_valid` and `cpu_done` are low.
- R2: A read whose line is Valid with a matching tag raises `cpu_done` in the same cycle as `cpu_req`. It returns the cached word and raises neither `bus_req` nor `bus_cmd_valid`.
- R3: A read that misses requests the bus. In the cycle after grant it drives a one-cycle bus read (`bus_cmd_wr` = 0) with the request address, returns `bus_rdata` on `cpu_rdata` with `cpu_done`, and leaves the line Valid, so that an identical read then hits.
- R4: Every write, hit or miss, requests the bus. In the cycle after grant it drives a bus write (`bus_cmd_wr` = 1) carrying the address and data, and raises `cpu_done` in that cycle.
- R5: A write to an Invalid line does not allocate it: a later read of that address misses and goes to the bus.
- R6: A write to a Valid line also updates the cached word, so a later read hits and returns the new data.
- R7: A snooped write whose address matches a Valid line makes the line Invalid, so the next read of that address misses.
- R8: A snooped write with the same index but a different tag, or one aimed at an Invalid line, leaves the cache unchanged, and the next read of the resident address still hits.
- R9: If a snooped write invalidates the very line being read in the same cycle as a read hit, the hit is suppressed (no `cpu_done`), and the read is retried as a miss through the bus.
- R10: While waiting for grant, `bus_req` stays high, and neither `bus_cmd_valid` nor `cpu_done` is raised.
- R11: A command is driven for exactly one cycle, only after a cycle in which both request and grant were high, and `bus_req` drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with done on reads |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command driven this cycle |
| bus_cmd_wr | output | 1 | Command kind, 1 = write |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write data on the bus |
| bus_rdata | input | DATA_W | Memory read data during a bus read |
| snp_wr_valid | input | 1 | Another cache writes this cycle |
| snp_addr | input | ADDR_W | Address of that foreign write |

## Verification
Some rules are checked by assertions on every cycle. These cover the bus handshake: a command only follows request plus grant, lasts one cycle, and drops the request after it. A write completes only together with a bus write, a bus read is always accompanied by done, and a completion without bus traffic is always a read. The state of each line is checked only by the bench's scenarios. A reference model mirrors the tag store and memory and is compared on every clock. These scenarios cover fill on a read miss, no-allocate on a write miss, update on a write hit, invalidation by a matching snoop, immunity to non-matching snoops, and the retry when a snoop collides with a hit.

// File: rtl/wtinv_pkg.sv
package wtinv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } wtinv_state_e;
endpackage

// File: rtl/wtinv_line_store.sv
module wtinv_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              snp_v,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag,
    output logic              snp_kill,
    input  logic              fill_en,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NLINES = 1 << IDX_W;

    logic [NLINES-1:0] valid_q;
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [DATA_W-1:0] data_q [NLINES];

    // A foreign write kills a line only if it is resident with that tag.
    assign snp_kill = snp_v && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              sel_wr;
        logic              sel_snp;

        assign sel_wr  = (wr_idx == IDX_W'(g));
        assign sel_snp = snp_kill && (snp_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else begin
                if (fill_en && sel_wr) begin
                    v_q <= 1'b1;
                    t_q <= wr_tag;
                end else if (sel_snp) begin
                    v_q <= 1'b0;
                end
                if ((fill_en || upd_en) && sel_wr) begin
                    d_q <= wr_data;
                end
            end
        end

        assign valid_q[g] = v_q;
        assign tag_q[g]   = t_q;
        assign data_q[g]  = d_q;
    end
endmodule

// File: rtl/wtinv_seq.sv
module wtinv_seq
    import wtinv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic collide,
    input  logic bus_gnt,
    output logic bus_req,
    output logic cmd_valid,
    output logic done,
    output logic fill_en,
    output logic upd_en,
    output logic sel_bus
);
    wtinv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && (cpu_we || !hit)) state_d = ST_WAIT;
            ST_WAIT:  if (bus_gnt) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_req   = 1'b0;
        cmd_valid = 1'b0;
        done      = 1'b0;
        fill_en   = 1'b0;
        upd_en    = 1'b0;
        sel_bus   = 1'b0;
        unique case (state_q)
            ST_IDLE:  done = cpu_req && !cpu_we && hit && !collide;
            ST_WAIT:  bus_req = 1'b1;
            ST_ISSUE: begin
                bus_req   = 1'b1;
                cmd_valid = 1'b1;
                done      = 1'b1;
                sel_bus   = 1'b1;
                fill_en   = !cpu_we;
                upd_en    = cpu_we && hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wtinv_cache_ctrl.sv
module wtinv_cache_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_wr_valid,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, s_idx;
    logic [TAG_W-1:0]  cpu_tag, s_tag, rd_tag;
    logic              rd_valid, hit, collide, snp_kill;
    logic [DATA_W-1:0] rd_data, fill_data;
    logic              cmd_valid, fill_en, upd_en, sel_bus;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx   = snp_addr[IDX_W-1:0];
    assign s_tag   = snp_addr[ADDR_W-1:IDX_W];

    assign hit     = rd_valid && (rd_tag == cpu_tag);
    assign collide = snp_kill && (s_idx == cpu_idx);
    assign fill_data = cpu_we ? cpu_wdata : bus_rdata;

    wtinv_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cpu_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .snp_v    (snp_wr_valid),
        .snp_idx  (s_idx),
        .snp_tag  (s_tag),
        .snp_kill (snp_kill),
        .fill_en  (fill_en),
        .upd_en   (upd_en),
        .wr_idx   (cpu_idx),
        .wr_tag   (cpu_tag),
        .wr_data  (fill_data)
    );

    wtinv_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .collide   (collide),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .cmd_valid (cmd_valid),
        .done      (cpu_done),
        .fill_en   (fill_en),
        .upd_en    (upd_en),
        .sel_bus   (sel_bus)
    );

    assign bus_cmd_valid = cmd_valid;
    assign bus_cmd_wr    = cmd_valid && cpu_we;
    assign bus_addr      = cmd_valid ? cpu_addr : '0;
    assign bus_wdata     = (cmd_valid && cpu_we) ? cpu_wdata : '0;
    assign cpu_rdata     = sel_bus ? bus_rdata : rd_data;
endmodule

// File: rtl/wtinv_checker.sv
module wtinv_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_done,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_cmd_valid,
    input logic bus_cmd_wr
);
    a_r11_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> $past(bus_req) && $past(bus_gnt));

    a_r11_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |=> !bus_cmd_valid && !bus_req);

    a_r4_write_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_req && cpu_we) |-> (bus_cmd_valid && bus_cmd_wr));

    a_r2_local_done_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !bus_cmd_valid) |-> (!cpu_we && !bus_req));

    a_r3_bus_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && !bus_cmd_wr) |-> cpu_done);

    a_r10_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_cmd_valid) |-> !cpu_done);
endmodule

bind wtinv_cache_ctrl wtinv_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd_wr    (bus_cmd_wr)
);

// File: tb/sim_wtinv_cache_ctrl.sv
`timescale 1ns/1ps
module sim_wtinv_cache_ctrl;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int IW = 3;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic cpu_done, bus_req, bus_cmd_valid, bus_cmd_wr;
    logic bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic snp_wr_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    logic [DW-1:0] mem [1 << AW];
    assign bus_rdata = mem[bus_addr];

    int checks = 0, failures = 0, cyc = 0;
    string cur = "R1";

    always #5 clk = ~clk;

    wtinv_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u0 (.*);

    // Behavioural reference model
    int  m_phase;
    bit  m_v [NL];
    int  m_t [NL];
    int  m_d [NL];

    function automatic bit m_hit(input logic [AW-1:0] a);
        return m_v[a % NL] && (m_t[a % NL] == int'(a / NL));
    endfunction

    function automatic bit m_kill(input logic [AW-1:0] a);
        return snp_wr_valid && m_v[snp_addr % NL] && (m_t[snp_addr % NL] == int'(snp_addr / NL))
               && ((snp_addr % NL) == (a % NL));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s/%s cycle %0d: actual=%0h expected=%0h", tag, cur, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0;
            for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_t[i] = 0; m_d[i] = 0; end
        end else begin
            int  ix;
            bit  h;
            ix = cpu_addr % NL;
            h  = m_hit(cpu_addr);
            if (snp_wr_valid && m_v[snp_addr % NL] && (m_t[snp_addr % NL] == int'(snp_addr / NL)))
                m_v[snp_addr % NL] = 0;
            case (m_phase)
                0: if (cpu_req && (cpu_we || !h)) m_phase = 1;
                1: if (bus_gnt) m_phase = 2;
                default: begin
                    if (cpu_we) begin
                        if (h) m_d[ix] = cpu_wdata;
                        mem[cpu_addr] = cpu_wdata;
                    end else begin
                        m_v[ix] = 1; m_t[ix] = cpu_addr / NL; m_d[ix] = mem[cpu_addr];
                    end
                    m_phase = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_done;
            string lbl;
            e_done = (m_phase == 2) ||
                     (m_phase == 0 && cpu_req && !cpu_we && m_hit(cpu_addr) && !m_kill(cpu_addr));
            lbl = (m_phase == 1) ? "R10" : (m_phase == 2) ? (cpu_we ? "R4" : "R3") :
                  (e_done ? "R2" : "R11");
            chk(lbl, bus_req, m_phase != 0);
            chk(lbl, bus_cmd_valid, m_phase == 2);
            chk(lbl, cpu_done, e_done);
            if (e_done && !cpu_we)
                chk(lbl, cpu_rdata, (m_phase == 2) ? mem[cpu_addr] : m_d[cpu_addr % NL]);
            if (m_phase == 2) begin
                chk(lbl, bus_cmd_wr, cpu_we);
                chk(lbl, bus_addr, cpu_addr);
                chk(lbl, bus_wdata, cpu_we ? cpu_wdata : 0);
            end
        end
    end

    task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input int gdly, input int snp_at, input logic [AW-1:0] sa,
                      output int lat, output logic [DW-1:0] rd);
        int g = 0;
        lat = 0;
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        snp_wr_valid = (snp_at == 0); snp_addr = sa;
        forever begin
            @(negedge clk); #1;
            if (cpu_done) begin rd = cpu_rdata; break; end
            lat++;
            if (lat > 100) begin rd = '0; break; end
            @(posedge clk); #1;
            if (bus_req) g++;
            bus_gnt = bus_req && (g > gdly);
            snp_wr_valid = (snp_at == lat);
        end
        @(posedge clk); #1;
        cpu_req = 0; bus_gnt = 0; snp_wr_valid = 0;
    endtask

    task automatic snoop(input logic [AW-1:0] sa);
        @(posedge clk); #1;
        snp_wr_valid = 1; snp_addr = sa;
        @(posedge clk); #1;
        snp_wr_valid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int lat;
        logic [DW-1:0] rd;
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'((i * 37) ^ 16'h5A3C);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        cur = "R1";
        chk("R1", bus_req, 0); chk("R1", bus_cmd_valid, 0); chk("R1", cpu_done, 0);
        op(0, 12'h013, 0, 0, -1, 0, lat, rd);
        chk("R1", lat, 2);
        cur = "R3";
        chk("R3", rd, mem[12'h013]);
        cur = "R2";
        op(0, 12'h013, 0, 0, -1, 0, lat, rd);
        chk("R2", lat, 0); chk("R2", rd, mem[12'h013]);
        cur = "R10";
        op(0, 12'h024, 0, 3, -1, 0, lat, rd);
        chk("R10", lat, 5);
        cur = "R4";
        op(1, 12'h035, 16'h1111, 0, -1, 0, lat, rd);
        chk("R4", lat, 2);
        cur = "R5";
        op(0, 12'h035, 0, 0, -1, 0, lat, rd);
        chk("R5", lat, 2); chk("R5", rd, 16'h1111);
        cur = "R6";
        op(1, 12'h013, 16'h2222, 1, -1, 0, lat, rd);
        chk("R6", lat, 3);
        op(0, 12'h013, 0, 0, -1, 0, lat, rd);
        chk("R6", lat, 0); chk("R6", rd, 16'h2222);
        cur = "R7";
        snoop(12'h013);
        op(0, 12'h013, 0, 0, -1, 0, lat, rd);
        chk("R7", lat, 2); chk("R7", rd, 16'h2222);
        cur = "R8";
        op(0, 12'h046, 0, 0, -1, 0, lat, rd);
        snoop(12'h146);
        snoop(12'h047);
        op(0, 12'h046, 0, 0, -1, 0, lat, rd);
        chk("R8", lat, 0); chk("R8", rd, mem[12'h046]);
        cur = "R9";
        op(0, 12'h046, 0, 0, 0, 12'h046, lat, rd);
        chk("R9", lat, 3); chk("R9", rd, mem[12'h046]);
        cur = "R11";
        op(1, 12'h046, 16'h3333, 2, -1, 0, lat, rd);
        chk("R11", lat, 4);
        op(0, 12'h046, 0, 0, -1, 0, lat, rd);
        chk("R11", rd, 16'h3333);
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule